// File: doc/BRIEF.md
# Interrupt Enable and Shadow Controller

This block performs the "set interrupt flag" operation of a processor core and keeps the one-instruction interrupt shadow that follows it. At the boundary where the set operation retires, it looks at the current operating state. That state is protection on or off, virtual-8086 or not, the two virtualisation extension enables, the privilege level, the I/O privilege level and the virtual-interrupt-pending bit. From these the block chooses one outcome: set the interrupt flag, set the virtual interrupt flag, or report a fault. The fault is an undefined-opcode fault when a lock prefix is present, and a general-protection fault with error code zero otherwise.

When the interrupt flag goes from 0 to 1, a shadow register holds maskable interrupts off for one more instruction boundary. A separate output can also hold off non-maskable and system-management interrupts for that boundary. The shadow is dropped by the next retire of any instruction or by delivery of an event. A clear-flag operation that retires right after the set operation clears the flag at the same edge that the shadow drops, so no maskable interrupt can be accepted between the two. Decode, fault delivery and the interrupt controller sit outside this block.

Top module: `int_enable_shadow`

## Requirements
- R1: When `protEn` is 0, a set retire (`retireKind` = 2'd1) sets `intFlag` to 1 whatever the other state inputs are, provided `lockPfx` is 0.
- R2: When `protEn` is 1 and the I/O privilege level is greater than or equal to the effective privilege level, a set retire sets `intFlag`. The effective level is `cpl`, or the maximum level (3) when `v86Mode` is 1.
- R3: When the privilege check of R2 fails, an extension mode is active and `vipBit` is 0, a set retire sets `virtIntFlag` and leaves `intFlag` unchanged.
- R4: When the privilege check fails and either `vipBit` is 1 or no extension mode is active, `gpFault` is high combinationally in the set-retire cycle. The fault carries error code zero, and neither flag changes.
- R5: The protected extension mode is active only with `protEn`=1, `v86Mode`=0, `cpl`=3 and `pvirtEn`=1. The virtual-8086 extension mode is active only with `protEn`=1, `v86Mode`=1 and `vmExtEn`=1.
- R6: A lock prefix on a set retire raises `udFault` and never `gpFault`, in every mode, and changes no flag. `gpFault` and `udFault` are low whenever `retireKind` is not 2'd1.
- R7: A successful set retire arms the shadow only if `intFlag` was 0 before it. `maskInhibit` equals NOT `intFlag` OR the shadow.
- R8: The shadow persists through idle cycles (`retireKind` = 2'd0). It is cleared at the edge of the next retire of any kind (2'd1, 2'd2 or 2'd3) or of `eventDeliver`.
- R9: A clear retire (`retireKind` = 2'd2) clears `intFlag`. Right after a set, `maskInhibit` therefore stays high across the boundary.
- R10: `nmiInhibit` is high exactly while the shadow is armed (with the default `NMI_SHADOW_EN` = 1).
- R11: Reset clears `intFlag`, `virtIntFlag` and the shadow.
- R12: When `eventDeliver` coincides with a successful set retire, the flag is still set but no shadow is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protEn | input | 1 | Protection enabled |
| v86Mode | input | 1 | Virtual-8086 mode active |
| vmExtEn | input | 1 | Virtual-8086 extension enable |
| pvirtEn | input | 1 | Protected-mode virtual interrupt enable |
| cpl | input | PL_W | Current privilege level |
| iopl | input | PL_W | I/O privilege level |
| vipBit | input | 1 | Virtual interrupt pending |
| lockPfx | input | 1 | Lock prefix present on the retiring instruction |
| retireKind | input | 2 | 0 none, 1 set-flag, 2 clear-flag, 3 other instruction |
| eventDeliver | input | 1 | An exception or interrupt is being delivered |
| intFlag | output | 1 | Interrupt flag |
| virtIntFlag | output | 1 | Virtual interrupt flag |
| gpFault | output | 1 | General-protection fault (code 0) for this set retire |
| udFault | output | 1 | Undefined-opcode fault for this set retire |
| maskInhibit | output | 1 | Maskable interrupts blocked |
| nmiInhibit | output | 1 | NMI/SMI blocked for the shadow boundary |

## Verification
The hard situations are those that need a particular flag value before the set retire. One is a shadow armed while the next instruction is a clear. Another is the set retire with the flag already 1. The bench reaches each of these through the ports alone. For the flag-already-set start, it first retires a set operation with protection off and then retires an unrelated instruction to drop the shadow. The bench then sweeps all 2048 combinations of mode bits, privilege levels, pending bit, lock prefix and starting flag. It ends each case with a different retire kind or an event, so that every way of ending the shadow is exercised.

// File: rtl/ies_pkg.sv
package ies_pkg;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_SET   = 2'd1,
    RK_CLEAR = 2'd2,
    RK_OTHER = 2'd3
  } retireKind_e;

  typedef enum logic [1:0] {
    DEC_UD,
    DEC_IF,
    DEC_VIF,
    DEC_GP
  } decision_e;

  typedef struct packed {
    logic setIf;
    logic setVif;
    logic clrIf;
    logic armShadow;
    logic dropShadow;
  } ctlStrobes_t;

endpackage

// File: rtl/ies_ctrl.sv
module ies_ctrl
  import ies_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            protEn,
  input  logic            v86Mode,
  input  logic            vmExtEn,
  input  logic            pvirtEn,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] iopl,
  input  logic            vipBit,
  input  logic            lockPfx,
  input  retireKind_e     kind,
  input  logic            eventDeliver,
  input  logic            intFlagQ,
  output ctlStrobes_t     strobes,
  output logic            gpFault,
  output logic            udFault
);

  localparam logic [PL_W-1:0] PL_MAX = {PL_W{1'b1}};

  logic [PL_W-1:0] effCpl;
  logic            ioplOk;
  logic            pviActive;
  logic            vmeActive;
  logic            isSet;
  decision_e       decision;

  always_comb begin
    isSet     = (kind == RK_SET);
    effCpl    = v86Mode ? PL_MAX : cpl;
    ioplOk    = (iopl >= effCpl);
    pviActive = protEn && !v86Mode && (cpl == PL_MAX) && pvirtEn;
    vmeActive = protEn && v86Mode && vmExtEn;

    // Lock check first, then privilege, then virtual path.
    if (lockPfx)                              decision = DEC_UD;
    else if (!protEn || ioplOk)               decision = DEC_IF;
    else if ((pviActive || vmeActive) && !vipBit) decision = DEC_VIF;
    else                                      decision = DEC_GP;
  end

  always_comb begin
    strobes.setIf      = isSet && (decision == DEC_IF);
    strobes.setVif     = isSet && (decision == DEC_VIF);
    strobes.clrIf      = (kind == RK_CLEAR);
    strobes.armShadow  = strobes.setIf && !intFlagQ && !eventDeliver;
    strobes.dropShadow = (kind != RK_NONE) || eventDeliver;
    gpFault            = isSet && (decision == DEC_GP);
    udFault            = isSet && (decision == DEC_UD);
  end

endmodule

// File: rtl/ies_datapath.sv
module ies_datapath
  import ies_pkg::*;
#(
  parameter bit NMI_SHADOW_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  output logic        intFlagQ,
  output logic        virtIntFlagQ,
  output logic        maskInhibit,
  output logic        nmiInhibit
);

  logic shadowQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intFlagQ     <= 1'b0;
      virtIntFlagQ <= 1'b0;
      shadowQ      <= 1'b0;
    end else begin
      if (strobes.clrIf)      intFlagQ <= 1'b0;
      else if (strobes.setIf) intFlagQ <= 1'b1;

      if (strobes.setVif) virtIntFlagQ <= 1'b1;

      if (strobes.armShadow)       shadowQ <= 1'b1;
      else if (strobes.dropShadow) shadowQ <= 1'b0;
    end
  end

  assign maskInhibit = !intFlagQ || shadowQ;

  generate
    if (NMI_SHADOW_EN) begin : g_nmiShadow
      assign nmiInhibit = shadowQ;
    end else begin : g_noNmiShadow
      assign nmiInhibit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/int_enable_shadow.sv
module int_enable_shadow
  import ies_pkg::*;
#(
  parameter int PL_W          = 2,
  parameter bit NMI_SHADOW_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            protEn,
  input  logic            v86Mode,
  input  logic            vmExtEn,
  input  logic            pvirtEn,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] iopl,
  input  logic            vipBit,
  input  logic            lockPfx,
  input  logic [1:0]      retireKind,
  input  logic            eventDeliver,
  output logic            intFlag,
  output logic            virtIntFlag,
  output logic            gpFault,
  output logic            udFault,
  output logic            maskInhibit,
  output logic            nmiInhibit
);

  ctlStrobes_t strobes;
  retireKind_e kind;

  assign kind = retireKind_e'(retireKind);

  ies_ctrl #(.PL_W(PL_W)) ctrl_i (
    .protEn      (protEn),
    .v86Mode     (v86Mode),
    .vmExtEn     (vmExtEn),
    .pvirtEn     (pvirtEn),
    .cpl         (cpl),
    .iopl        (iopl),
    .vipBit      (vipBit),
    .lockPfx     (lockPfx),
    .kind        (kind),
    .eventDeliver(eventDeliver),
    .intFlagQ    (intFlag),
    .strobes     (strobes),
    .gpFault     (gpFault),
    .udFault     (udFault)
  );

  ies_datapath #(.NMI_SHADOW_EN(NMI_SHADOW_EN)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .intFlagQ    (intFlag),
    .virtIntFlagQ(virtIntFlag),
    .maskInhibit (maskInhibit),
    .nmiInhibit  (nmiInhibit)
  );

endmodule

// File: rtl/int_enable_shadow_chk.sv
module int_enable_shadow_chk (
  input logic       clk,
  input logic       rstN,
  input logic       lockPfx,
  input logic [1:0] retireKind,
  input logic       eventDeliver,
  input logic       intFlag,
  input logic       virtIntFlag,
  input logic       gpFault,
  input logic       udFault,
  input logic       maskInhibit,
  input logic       nmiInhibit
);

  AST_LOCK_IS_UD: assert property (@(posedge clk) disable iff (!rstN)
    (lockPfx && retireKind == 2'd1) |-> (udFault && !gpFault)); // R6

  AST_FAULT_ONLY_ON_SET: assert property (@(posedge clk) disable iff (!rstN)
    (gpFault || udFault) |-> (retireKind == 2'd1)); // R6

  AST_FAULT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (gpFault || udFault) |=> ($stable(intFlag) && $stable(virtIntFlag))); // R4

  AST_SHADOW_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiInhibit) |-> (intFlag && !$past(intFlag))); // R7

  AST_MASK_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !intFlag |-> maskInhibit); // R7

  AST_SHADOW_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (nmiInhibit && (retireKind != 2'd0 || eventDeliver)) |=> !nmiInhibit); // R8

  AST_CLEAR_OP: assert property (@(posedge clk) disable iff (!rstN)
    (retireKind == 2'd2) |=> !intFlag); // R9

  AST_NO_SHADOW_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    eventDeliver |=> !nmiInhibit); // R12

endmodule

bind int_enable_shadow int_enable_shadow_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .lockPfx     (lockPfx),
  .retireKind  (retireKind),
  .eventDeliver(eventDeliver),
  .intFlag     (intFlag),
  .virtIntFlag (virtIntFlag),
  .gpFault     (gpFault),
  .udFault     (udFault),
  .maskInhibit (maskInhibit),
  .nmiInhibit  (nmiInhibit)
);

// File: tb/int_enable_shadow_tb_top.sv
module int_enable_shadow_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       protEn = 1'b0, v86Mode = 1'b0, vmExtEn = 1'b0, pvirtEn = 1'b0;
  logic [1:0] cpl = 2'd0, iopl = 2'd0;
  logic       vipBit = 1'b0, lockPfx = 1'b0;
  logic [1:0] retireKind = 2'd0;
  logic       eventDeliver = 1'b0;
  logic       intFlag, virtIntFlag, gpFault, udFault, maskInhibit, nmiInhibit;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  int_enable_shadow dut_i (
    .clk(clk), .rstN(rstN), .protEn(protEn), .v86Mode(v86Mode),
    .vmExtEn(vmExtEn), .pvirtEn(pvirtEn), .cpl(cpl), .iopl(iopl),
    .vipBit(vipBit), .lockPfx(lockPfx), .retireKind(retireKind),
    .eventDeliver(eventDeliver), .intFlag(intFlag), .virtIntFlag(virtIntFlag),
    .gpFault(gpFault), .udFault(udFault), .maskInhibit(maskInhibit),
    .nmiInhibit(nmiInhibit)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; retireKind = 2'd0; eventDeliver = 1'b0; lockPfx = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runCase(input int idx);
    bit lk, vp, pvE, vmE, v86, pe, ifStart;
    int cp, io, follow, effC;
    bit ok, pviA, vmeA, eUd, eIf, eVif, eGp, expIf, expVif, expSh;
    lk = idx[0]; vp = idx[1]; pvE = idx[2]; vmE = idx[3];
    v86 = idx[4]; pe = idx[5]; cp = (idx >> 6) & 3; io = (idx >> 8) & 3;
    ifStart = idx[10]; follow = idx % 3;

    doReset();
    chk("R11", "intFlag after reset", int'(intFlag), 0);
    chk("R11", "virtIntFlag after reset", int'(virtIntFlag), 0);
    chk("R11", "nmiInhibit after reset", int'(nmiInhibit), 0);

    if (ifStart) begin
      protEn = 1'b0; lockPfx = 1'b0; retireKind = 2'd1;
      @(negedge clk); retireKind = 2'd3;
      @(negedge clk); retireKind = 2'd0;
      chk("R1", "intFlag preset", int'(intFlag), 1);
    end

    // expected outcome from the decision rules
    effC = v86 ? 3 : cp;
    ok   = !pe || (io >= effC);
    pviA = pe && !v86 && (cp == 3) && pvE;
    vmeA = pe && v86 && vmE;
    eUd  = lk;
    eIf  = !eUd && ok;
    eVif = !eUd && !ok && (pviA || vmeA) && !vp;
    eGp  = !eUd && !ok && !eVif;
    expIf  = ifStart || eIf;
    expVif = eVif;
    expSh  = eIf && !ifStart;

    protEn = pe; v86Mode = v86; vmExtEn = vmE; pvirtEn = pvE;
    cpl = 2'(cp); iopl = 2'(io); vipBit = vp; lockPfx = lk; retireKind = 2'd1;
    #2;
    chk("R6", "udFault", int'(udFault), int'(eUd));
    chk("R4", "gpFault", int'(gpFault), int'(eGp));
    @(negedge clk);
    retireKind = 2'd0; lockPfx = 1'b0;
    chk(pe ? "R2" : "R1", "intFlag after set", int'(intFlag), int'(expIf));
    chk("R3", "virtIntFlag after set", int'(virtIntFlag), int'(expVif));
    chk("R7", "shadow armed", int'(nmiInhibit), int'(expSh));
    chk("R10", "maskInhibit", int'(maskInhibit), int'(!expIf || expSh));
    @(negedge clk);
    chk("R8", "shadow held over idle", int'(nmiInhibit), int'(expSh));

    if (follow == 2) eventDeliver = 1'b1;
    else retireKind = (follow == 1) ? 2'd2 : 2'd3;
    if (follow == 1 && expSh)
      chk("R9", "mask high before clear edge", int'(maskInhibit), 1);
    @(negedge clk);
    retireKind = 2'd0; eventDeliver = 1'b0;
    chk("R8", "shadow dropped", int'(nmiInhibit), 0);
    chk("R9", "intFlag after follow", int'(intFlag), (follow == 1) ? 0 : int'(expIf));
    chk("R9", "maskInhibit after follow", int'(maskInhibit),
        (follow == 1) ? 1 : int'(!expIf));
    chk("R3", "virtIntFlag kept", int'(virtIntFlag), int'(expVif));
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) runCase(i);

    // R12: event coincident with a successful set
    doReset();
    protEn = 1'b0; retireKind = 2'd1; eventDeliver = 1'b1;
    @(negedge clk);
    retireKind = 2'd0; eventDeliver = 1'b0;
    chk("R12", "intFlag with event", int'(intFlag), 1);
    chk("R12", "no shadow with event", int'(nmiInhibit), 0);

    // R5: protected extension needs cpl at maximum
    doReset();
    protEn = 1'b1; v86Mode = 1'b0; pvirtEn = 1'b1; cpl = 2'd2; iopl = 2'd1;
    vipBit = 1'b0; retireKind = 2'd1;
    #2;
    chk("R5", "gp below max cpl", int'(gpFault), 1);
    @(negedge clk);
    retireKind = 2'd0;
    chk("R5", "virtIntFlag untouched", int'(virtIntFlag), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule